// File: doc/BRIEF.md
# Multicart Bank Controller Register Interface

This block is the CPU-facing register file of a cartridge bank-switching controller built for multi-game carts. The CPU reaches it through two address windows. A write to the index window chooses one of four internal registers. A write to the data window loads the chosen register with the six low data bits. The four registers hold the 8 KiB CHR bank, the inner PRG bank, the mode word and the outer PRG bank.

A write to either bank register also carries a mirroring bit. That bit is copied into the low bit of the mode word, but only while the mode word is in a one-screen mirroring setting. The block turns the two mirroring bits of the mode word and the PPU address lines A10 and A11 into the CIRAM A10 line.

The registers get defined values only at power-up, so that the last 16 KiB bank is visible at the top of CPU space. The reset input leaves every register unchanged. While reset is held, CPU writes are ignored. All writes are taken on the rising clock edge.

Top module: `mm_regif`

## Requirements
- R1: A write whose address ANDed with $F000 equals $5000 latches a register index from data bit 7 (high) and data bit 0 (low). Index 00 selects CHR, 01 selects inner PRG, 10 selects mode and 11 selects outer PRG. Data bits 6:1 are ignored, and writes outside the window leave the index unchanged.
- R2: A write with address bit 15 set loads the indexed register. Data bits 7:6 are dropped. Writes to $0000-$7FFF outside the index window change no register.
- R3: Loading the CHR register sets `chr_bank` to data bits 1:0.
- R4: Loading the inner PRG register sets `prg_bank` to data bits 3:0.
- R5: Loading the mode register sets `mode_reg` to data bits 5:0. Loading the outer register sets `outer_bank` to data bits 5:0.
- R6: Loading the CHR or inner PRG register while `mode_reg` bit 1 is 0 copies data bit 4 into `mode_reg` bit 0.
- R7: Loading the CHR or inner PRG register while `mode_reg` bit 1 is 1 leaves `mode_reg` unchanged.
- R8: `ciram_a10` is 0 for mirroring code 00 and 1 for code 01. It follows `ppu_a10` for code 10 and `ppu_a11` for code 11, where the code is `mode_reg` bits 1:0.
- R9: At power-up `chr_bank`=0, `prg_bank`=0, `mode_reg`=$08 (16K mode, fixed top half, smallest game size, one-screen A), `outer_bank`=$3F, and the index selects CHR.
- R10: While `rst` is high, no write changes any register or the index. Releasing reset restores no value.
- R11: A register changes only at a rising clock edge where `cpu_wr` is high. A window address with `cpu_wr` low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock on which CPU writes are sampled |
| rst | input | 1 | Reset; blocks writes and preserves all registers |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_a10 | input | 1 | PPU address line A10 |
| ppu_a11 | input | 1 | PPU address line A11 |
| chr_bank | output | 2 | Selected 8 KiB CHR bank |
| prg_bank | output | 4 | Inner PRG bank register |
| mode_reg | output | 6 | Mode word: game size 5:4, PRG size 3, slot 2, mirroring 1:0 |
| outer_bank | output | 6 | Outer PRG bank register |
| ciram_a10 | output | 1 | Nametable RAM A10 select |

## Verification
The bench builds the block with its default parameters: a 16-bit CPU address, an 8-bit data bus, six-bit registers and the mirroring link enabled. With these values the exact window edges $4FFF/$5000/$5FFF/$6000 and $7FFF/$8000/$FFFF can be reached. So can the interaction in which a bank write changes the mode word, in both the locked and the unlocked mirroring state. The power-up values are checked before any write, and the reset-hold behaviour is checked by issuing writes to both windows while reset is high.

// File: rtl/mm_regif_pkg.sv
`timescale 1ns/1ps
package mm_regif_pkg;

   // Register index as formed from {data[7], data[0]} on an index-port write.
   typedef enum logic [1:0] {
      IDX_CHR   = 2'b00,
      IDX_PRG   = 2'b01,
      IDX_MODE  = 2'b10,
      IDX_OUTER = 2'b11
   } reg_idx_e;

   // Mirroring code held in the two low mode bits.
   typedef enum logic [1:0] {
      MIR_ONE_A = 2'b00,
      MIR_ONE_B = 2'b01,
      MIR_VERT  = 2'b10,
      MIR_HORZ  = 2'b11
   } mirror_e;

   localparam int MODE_MIR_LO  = 0;
   localparam int MODE_MIR_HI  = 1;
   localparam int BANK_MIR_BIT = 4;
   localparam int IDX_HI_BIT   = 7;
   localparam int IDX_LO_BIT   = 0;

   function automatic reg_idx_e idx_from_byte(input logic [7:0] b);
      return reg_idx_e'({b[IDX_HI_BIT], b[IDX_LO_BIT]});
   endfunction

endpackage

// File: rtl/mm_port_decode.sv
`timescale 1ns/1ps
module mm_port_decode #(
   parameter int               ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] IDX_MASK  = 16'hF000,
   parameter logic [ADDR_W-1:0] IDX_MATCH = 16'h5000,
   parameter logic [ADDR_W-1:0] DAT_MASK  = 16'h8000,
   parameter logic [ADDR_W-1:0] DAT_MATCH = 16'h8000
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic              idx_we,
   output logic              dat_we
);

   localparam logic [ADDR_W-1:0] OVERLAP = IDX_MASK & DAT_MASK;

   // The two windows must not claim the same address.
   if (((IDX_MATCH & OVERLAP) == (DAT_MATCH & OVERLAP)))
      $error("mm_port_decode: index and data windows overlap");
   if ((IDX_MATCH & ~IDX_MASK) != '0)
      $error("mm_port_decode: index match has bits outside its mask");
   if ((DAT_MATCH & ~DAT_MASK) != '0)
      $error("mm_port_decode: data match has bits outside its mask");

   logic idx_hit;
   logic dat_hit;

   always_comb begin
      idx_hit = ((addr & IDX_MASK) == IDX_MATCH);
      dat_hit = ((addr & DAT_MASK) == DAT_MATCH);
      idx_we  = wr && idx_hit;
      dat_we  = wr && dat_hit;
   end

endmodule

// File: rtl/mm_bank_regs.sv
`timescale 1ns/1ps
module mm_bank_regs
   import mm_regif_pkg::*;
#(
   parameter int              DATA_W      = 8,
   parameter int              REG_W       = 6,
   parameter int              CHR_W       = 2,
   parameter int              PRG_W       = 4,
   parameter bit              MIRROR_LINK = 1'b1,
   parameter logic [REG_W-1:0] MODE_INIT  = 6'h08,
   parameter logic [REG_W-1:0] OUTER_INIT = 6'h3F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              idx_we,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] data,
   output reg_idx_e          idx,
   output logic [CHR_W-1:0]  chr,
   output logic [PRG_W-1:0]  prg,
   output logic [REG_W-1:0]  mode,
   output logic [REG_W-1:0]  outer
);

   if (DATA_W != 8)
      $error("mm_bank_regs: index decode needs an 8-bit data bus");
   if (REG_W != 6)
      $error("mm_bank_regs: mode layout needs six-bit registers");
   if (CHR_W < 1 || CHR_W > BANK_MIR_BIT)
      $error("mm_bank_regs: CHR field collides with the mirroring bit");
   if (PRG_W < 1 || PRG_W > BANK_MIR_BIT)
      $error("mm_bank_regs: PRG field collides with the mirroring bit");

   // Power-up values; no reset branch restores them.
   reg_idx_e         idx_q   = IDX_CHR;
   logic [CHR_W-1:0] chr_q   = '0;
   logic [PRG_W-1:0] prg_q   = '0;
   logic [REG_W-1:0] mode_q  = MODE_INIT;
   logic [REG_W-1:0] outer_q = OUTER_INIT;

   logic link_en;
   logic unused_data_bit;

   assign unused_data_bit = data[IDX_HI_BIT-1];

   // Variant: whether bank writes may rewrite the low mirroring bit.
   if (MIRROR_LINK) begin : g_link
      assign link_en = !mode_q[MODE_MIR_HI];
   end else begin : g_nolink
      assign link_en = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst) begin
         if (idx_we)
            idx_q <= idx_from_byte(data);
         if (dat_we) begin
            unique case (idx_q)
               IDX_CHR: begin
                  chr_q <= data[CHR_W-1:0];
                  if (link_en)
                     mode_q[MODE_MIR_LO] <= data[BANK_MIR_BIT];
               end
               IDX_PRG: begin
                  prg_q <= data[PRG_W-1:0];
                  if (link_en)
                     mode_q[MODE_MIR_LO] <= data[BANK_MIR_BIT];
               end
               IDX_MODE:  mode_q  <= data[REG_W-1:0];
               IDX_OUTER: outer_q <= data[REG_W-1:0];
            endcase
         end
      end
   end

   assign idx   = idx_q;
   assign chr   = chr_q;
   assign prg   = prg_q;
   assign mode  = mode_q;
   assign outer = outer_q;

endmodule

// File: rtl/mm_mirror_mux.sv
`timescale 1ns/1ps
module mm_mirror_mux
   import mm_regif_pkg::*;
(
   input  logic [1:0] mir_code,
   input  logic       ppu_a10,
   input  logic       ppu_a11,
   output logic       ciram_a10
);

   mirror_e sel;

   always_comb begin
      sel = mirror_e'(mir_code);
      unique case (sel)
         MIR_ONE_A: ciram_a10 = 1'b0;
         MIR_ONE_B: ciram_a10 = 1'b1;
         MIR_VERT:  ciram_a10 = ppu_a10;
         MIR_HORZ:  ciram_a10 = ppu_a11;
      endcase
   end

endmodule

// File: rtl/mm_regif.sv
`timescale 1ns/1ps
module mm_regif
   import mm_regif_pkg::*;
#(
   parameter int               ADDR_W      = 16,
   parameter int               DATA_W      = 8,
   parameter int               REG_W       = 6,
   parameter int               CHR_W       = 2,
   parameter int               PRG_W       = 4,
   parameter logic [ADDR_W-1:0] IDX_MASK   = 16'hF000,
   parameter logic [ADDR_W-1:0] IDX_MATCH  = 16'h5000,
   parameter logic [ADDR_W-1:0] DAT_MASK   = 16'h8000,
   parameter logic [ADDR_W-1:0] DAT_MATCH  = 16'h8000,
   parameter bit               MIRROR_LINK = 1'b1,
   parameter logic [REG_W-1:0]  MODE_INIT  = 6'h08,
   parameter logic [REG_W-1:0]  OUTER_INIT = 6'h3F
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [15:0]       cpu_addr,
   input  logic [7:0]        cpu_data,
   input  logic              cpu_wr,
   input  logic              ppu_a10,
   input  logic              ppu_a11,
   output logic [1:0]        chr_bank,
   output logic [3:0]        prg_bank,
   output logic [5:0]        mode_reg,
   output logic [5:0]        outer_bank,
   output logic              ciram_a10
);

   if (ADDR_W != 16 || DATA_W != 8 || REG_W != 6 || CHR_W != 2 || PRG_W != 4)
      $error("mm_regif: port widths are fixed for this controller");

   logic     idx_we;
   logic     dat_we;
   reg_idx_e cur_idx;

   mm_port_decode #(
      .ADDR_W    (ADDR_W),
      .IDX_MASK  (IDX_MASK),
      .IDX_MATCH (IDX_MATCH),
      .DAT_MASK  (DAT_MASK),
      .DAT_MATCH (DAT_MATCH)
   ) u_decode (
      .addr   (cpu_addr),
      .wr     (cpu_wr),
      .idx_we (idx_we),
      .dat_we (dat_we)
   );

   mm_bank_regs #(
      .DATA_W      (DATA_W),
      .REG_W       (REG_W),
      .CHR_W       (CHR_W),
      .PRG_W       (PRG_W),
      .MIRROR_LINK (MIRROR_LINK),
      .MODE_INIT   (MODE_INIT),
      .OUTER_INIT  (OUTER_INIT)
   ) u_regs (
      .clk    (clk),
      .rst    (rst),
      .idx_we (idx_we),
      .dat_we (dat_we),
      .data   (cpu_data),
      .idx    (cur_idx),
      .chr    (chr_bank),
      .prg    (prg_bank),
      .mode   (mode_reg),
      .outer  (outer_bank)
   );

   mm_mirror_mux u_mirror (
      .mir_code  (mode_reg[MODE_MIR_HI:MODE_MIR_LO]),
      .ppu_a10   (ppu_a10),
      .ppu_a11   (ppu_a11),
      .ciram_a10 (ciram_a10)
   );

endmodule

// File: rtl/mm_regif_chk.sv
`timescale 1ns/1ps
module mm_regif_chk
   import mm_regif_pkg::*;
(
   input logic       clk,
   input logic       rst,
   input logic [7:0] cpu_data,
   input logic       ppu_a10,
   input logic       ppu_a11,
   input logic       idx_we,
   input logic       dat_we,
   input reg_idx_e   cur_idx,
   input logic [1:0] chr_bank,
   input logic [3:0] prg_bank,
   input logic [5:0] mode_reg,
   input logic [5:0] outer_bank,
   input logic       ciram_a10
);

   assert_index_latch_R1: assert property (@(posedge clk) disable iff (rst)
      idx_we |=> cur_idx == $past(reg_idx_e'({cpu_data[7], cpu_data[0]})));

   assert_chr_hold_R2: assert property (@(posedge clk) disable iff (rst)
      !dat_we |=> $stable(chr_bank));

   assert_outer_load_R5: assert property (@(posedge clk) disable iff (rst)
      (dat_we && cur_idx == IDX_OUTER) |=> outer_bank == $past(cpu_data[5:0]));

   assert_mirror_lock_R7: assert property (@(posedge clk) disable iff (rst)
      (dat_we && !cur_idx[1] && mode_reg[1]) |=> $stable(mode_reg));

   assert_vert_follow_R8: assert property (@(posedge clk) disable iff (rst)
      (mode_reg[1:0] == 2'b10) |-> ciram_a10 == ppu_a10);

   assert_horz_follow_R8: assert property (@(posedge clk) disable iff (rst)
      (mode_reg[1:0] == 2'b11) |-> ciram_a10 == ppu_a11);

   // Reset-hold window tracked with registered copies.
   logic       seen_q  = 1'b0;
   logic       rst_p   = 1'b0;
   logic [5:0] mode_p  = '0;
   logic [5:0] outer_p = '0;
   logic [3:0] prg_p   = '0;
   logic [1:0] chr_p   = '0;

   always_ff @(posedge clk) begin
      seen_q  <= 1'b1;
      rst_p   <= rst;
      mode_p  <= mode_reg;
      outer_p <= outer_bank;
      prg_p   <= prg_bank;
      chr_p   <= chr_bank;
   end

   always_ff @(posedge clk) begin
      if (seen_q && rst_p)
         assert_hold_in_reset_R10: assert (mode_reg == mode_p && outer_bank == outer_p &&
                                           prg_bank == prg_p && chr_bank == chr_p);
   end

endmodule

bind mm_regif mm_regif_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .cpu_data   (cpu_data),
   .ppu_a10    (ppu_a10),
   .ppu_a11    (ppu_a11),
   .idx_we     (idx_we),
   .dat_we     (dat_we),
   .cur_idx    (cur_idx),
   .chr_bank   (chr_bank),
   .prg_bank   (prg_bank),
   .mode_reg   (mode_reg),
   .outer_bank (outer_bank),
   .ciram_a10  (ciram_a10)
);

// File: tb/mm_regif_tb.sv
`timescale 1ns/1ps
module mm_regif_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        cpu_wr = 1'b0;
   logic        ppu_a10 = 1'b0;
   logic        ppu_a11 = 1'b0;
   logic [1:0]  chr_bank;
   logic [3:0]  prg_bank;
   logic [5:0]  mode_reg;
   logic [5:0]  outer_bank;
   logic        ciram_a10;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   mm_regif u_dut (
      .clk        (clk),
      .rst        (rst),
      .cpu_addr   (cpu_addr),
      .cpu_data   (cpu_data),
      .cpu_wr     (cpu_wr),
      .ppu_a10    (ppu_a10),
      .ppu_a11    (ppu_a11),
      .chr_bank   (chr_bank),
      .prg_bank   (prg_bank),
      .mode_reg   (mode_reg),
      .outer_bank (outer_bank),
      .ciram_a10  (ciram_a10)
   );

   task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Drive on the falling edge, capture on the rising edge, release on the next falling edge.
   task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      cpu_addr = a;
      cpu_data = d;
      cpu_wr   = 1'b1;
      @(negedge clk);
      cpu_wr   = 1'b0;
   endtask

   task automatic t_powerup;
      @(negedge clk);
      check("R9", "chr", {6'd0, chr_bank}, 8'h00);
      check("R9", "prg", {4'd0, prg_bank}, 8'h00);
      check("R9", "mode", {2'd0, mode_reg}, 8'h08);
      check("R9", "outer", {2'd0, outer_bank}, 8'h3F);
      check("R9", "ciram", {7'd0, ciram_a10}, 8'h00);
   endtask

   task automatic t_reset_hold;
      cpu_write(16'h5000, 8'h81);
      cpu_write(16'h8000, 8'h15);
      check("R10", "outer in reset", {2'd0, outer_bank}, 8'h3F);
      check("R10", "chr in reset", {6'd0, chr_bank}, 8'h00);
      check("R10", "mode in reset", {2'd0, mode_reg}, 8'h08);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R10", "outer after release", {2'd0, outer_bank}, 8'h3F);
      // Index write was blocked, so this lands in CHR.
      cpu_write(16'h8000, 8'h02);
      check("R10", "index kept through reset", {6'd0, chr_bank}, 8'h02);
      check("R10", "outer untouched", {2'd0, outer_bank}, 8'h3F);
   endtask

   task automatic t_index_port;
      cpu_write(16'h5FFF, 8'h81);
      cpu_write(16'h8000, 8'h2A);
      check("R1", "outer via top of window", {2'd0, outer_bank}, 8'h2A);
      cpu_write(16'h5123, 8'h7E);
      cpu_write(16'hFFFF, 8'h03);
      check("R1", "chr with bits 6:1 ignored", {6'd0, chr_bank}, 8'h03);
      check("R3", "chr value", {6'd0, chr_bank}, 8'h03);
      cpu_write(16'h4FFF, 8'h81);
      cpu_write(16'h6000, 8'h81);
      cpu_write(16'h8000, 8'h01);
      check("R1", "outside window keeps index", {6'd0, chr_bank}, 8'h01);
      check("R1", "outer not hit", {2'd0, outer_bank}, 8'h2A);
      cpu_write(16'h5000, 8'h80);
      cpu_write(16'hC000, 8'hF3);
      check("R5", "mode low six bits", {2'd0, mode_reg}, 8'h33);
      check("R2", "upper data bits dropped", {2'd0, mode_reg}, 8'h33);
   endtask

   task automatic t_data_port;
      cpu_write(16'h5000, 8'h01);
      cpu_write(16'h7FFF, 8'h05);
      check("R2", "below data window", {4'd0, prg_bank}, 8'h00);
      // Window address with strobe low.
      @(negedge clk);
      cpu_addr = 16'h8000;
      cpu_data = 8'h07;
      @(negedge clk);
      check("R11", "no strobe no write", {4'd0, prg_bank}, 8'h00);
      cpu_write(16'hA000, 8'hE6);
      check("R4", "prg low four bits", {4'd0, prg_bank}, 8'h06);
      cpu_write(16'h8000, 8'h1C);
      check("R4", "prg value", {4'd0, prg_bank}, 8'h0C);
      check("R7", "mode locked", {2'd0, mode_reg}, 8'h33);
      cpu_write(16'h5000, 8'h81);
      cpu_write(16'h8000, 8'h15);
      check("R5", "outer load", {2'd0, outer_bank}, 8'h15);
   endtask

   task automatic t_mirror_link;
      cpu_write(16'h5000, 8'h80);
      cpu_write(16'h8000, 8'h04);
      check("R5", "mode load", {2'd0, mode_reg}, 8'h04);
      cpu_write(16'h5000, 8'h00);
      cpu_write(16'h8000, 8'h11);
      check("R6", "chr write sets mirror bit", {2'd0, mode_reg}, 8'h05);
      check("R3", "chr with mirror bit", {6'd0, chr_bank}, 8'h01);
      cpu_write(16'h8000, 8'h02);
      check("R6", "chr write clears mirror bit", {2'd0, mode_reg}, 8'h04);
      cpu_write(16'h5000, 8'h01);
      cpu_write(16'h8000, 8'h13);
      check("R6", "prg write sets mirror bit", {2'd0, mode_reg}, 8'h05);
      check("R4", "prg with mirror bit", {4'd0, prg_bank}, 8'h03);
   endtask

   task automatic t_mirror_out;
      ppu_a10 = 1'b0; ppu_a11 = 1'b0;
      @(negedge clk);
      check("R8", "one-screen B", {7'd0, ciram_a10}, 8'h01);
      cpu_write(16'h5000, 8'h80);
      cpu_write(16'h8000, 8'h00);
      ppu_a10 = 1'b1; ppu_a11 = 1'b1;
      @(negedge clk);
      check("R8", "one-screen A", {7'd0, ciram_a10}, 8'h00);
      cpu_write(16'h8000, 8'h02);
      ppu_a10 = 1'b1; ppu_a11 = 1'b0;
      @(negedge clk);
      check("R8", "vertical a10=1", {7'd0, ciram_a10}, 8'h01);
      ppu_a10 = 1'b0; ppu_a11 = 1'b1;
      @(negedge clk);
      check("R8", "vertical a10=0", {7'd0, ciram_a10}, 8'h00);
      cpu_write(16'h8000, 8'h03);
      ppu_a10 = 1'b1; ppu_a11 = 1'b0;
      @(negedge clk);
      check("R8", "horizontal a11=0", {7'd0, ciram_a10}, 8'h00);
      ppu_a10 = 1'b0; ppu_a11 = 1'b1;
      @(negedge clk);
      check("R8", "horizontal a11=1", {7'd0, ciram_a10}, 8'h01);
   endtask

   initial begin
      t_powerup();
      t_reset_hold();
      t_index_port();
      t_data_port();
      t_mirror_link();
      t_mirror_out();
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule